// File: doc/BRIEF.md
# Chunked Stride Address Generator

This block produces the source and destination byte addresses for a single transfer whose data sits in memory as equal-sized chunks with gaps between them. A controller loads a start address for each side, a total byte count, a shared chunk length, a signed skip per side and a per-side increment enable. The generator then offers one address pair per beat over a valid/ready handshake and marks the beat that completes the byte count.

Inside a chunk, each incrementing side advances by one beat width. When a chunk finishes and more data remains, each incrementing side jumps by the beat width plus its own signed skip. A negative skip moves the next chunk backwards, and a skip larger than the chunk can place it anywhere. A chunk length of zero gives one contiguous run. A side with its increment enable clear keeps one fixed address, as a peripheral FIFO port would. The current address of both sides can be read at all times.

Top module: `csag_top`

## Requirements
- R1: After reset, beat_valid, beat_last, done and busy_err are 0, and cur_src and cur_dst are 0.
- R2: A load while idle with a nonzero total_bytes makes beat_valid high on the next cycle, with beat_src equal to src_start and beat_dst equal to dst_start.
- R3: With chunk_bytes zero, each accepted beat advances an incrementing side by BEAT_BYTES (4). The transfer has total_bytes/BEAT_BYTES beats.
- R4: With chunk_bytes nonzero, the beat after the one that completes a chunk has address = previous beat address + BEAT_BYTES + that side's skip. The skip is a 32-bit two's complement value, may be negative, may exceed the chunk length, and the sum wraps modulo 2^32.
- R5: beat_last is high only on the beat that completes total_bytes, including when that beat ends a partial final chunk. No skip follows the final beat.
- R6: A side whose increment enable was clear at load keeps its start address on every beat. Its skip has no effect.
- R7: While beat_valid is high and beat_ready is low, beat_valid, beat_src, beat_dst and beat_last hold their values.
- R8: One cycle after the last beat is accepted, done is high for one cycle and beat_valid is low.
- R9: A load while a transfer is active does not change the transfer in progress and sets busy_err. busy_err stays set until reset.
- R10: cur_src and cur_dst equal the address of the pending beat during a transfer. After completion they hold the addresses of the final beat.
- R11: A load while idle with total_bytes zero produces no beat, and done pulses on the next cycle.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a transfer with the configuration inputs |
| src_start | input | AW | First source byte address |
| dst_start | input | AW | First destination byte address |
| total_bytes | input | LW | Bytes to transfer, a multiple of BEAT_BYTES |
| chunk_bytes | input | LW | Shared chunk length, 0 for contiguous |
| src_skip | input | SKW | Signed gap added on the source side after each chunk |
| dst_skip | input | SKW | Signed gap added on the destination side after each chunk |
| src_inc | input | 1 | Source address advances when 1 |
| dst_inc | input | 1 | Destination address advances when 1 |
| beat_valid | output | 1 | An address pair is offered |
| beat_ready | input | 1 | Consumer accepts the offered pair |
| beat_src | output | AW | Source address of the offered beat |
| beat_dst | output | AW | Destination address of the offered beat |
| beat_last | output | 1 | Offered beat completes the transfer |
| done | output | 1 | One-cycle pulse after completion |
| busy_err | output | 1 | Sticky flag for a load rejected while active |
| cur_src | output | AW | Current source address readback |
| cur_dst | output | AW | Current destination address readback |

## Verification
Two cases can land in the same cycle. In the first, the final beat also ends a full chunk, so the skip logic and the last-beat logic disagree about what comes next. A 16-byte transfer with 8-byte chunks and a large source skip provokes this, and the check requires the readback addresses after done to equal the final beat's addresses with no skip applied. In the second, a load arrives while beats are still flowing. It is injected in the same cycle as an accepted beat, and the check requires the remaining address stream to match the original configuration while busy_err rises and stays high.

// File: rtl/csag_pkg.sv
package csag_pkg;

    typedef enum logic [0:0] {
        SIDE_SRC = 1'b0,
        SIDE_DST = 1'b1
    } side_e;

    localparam int NUM_SIDES = 2;

    // Per-beat decision shared by both address sides.
    typedef struct packed {
        logic fire;      // beat accepted this cycle
        logic final_b;   // accepted beat is the last of the transfer
        logic boundary;  // accepted beat closes a chunk
    } step_t;

    // Is a count at exactly one beat?
    function automatic logic at_one_beat(input logic [31:0] cnt, input int beat);
        return cnt == 32'(beat);
    endfunction

endpackage

// File: rtl/csag_side.sv
module csag_side
    import csag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SKW        = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [AW-1:0]  start_addr,
    input  logic [SKW-1:0] skip,
    input  logic           inc_en,
    input  step_t          step,
    output logic [AW-1:0]  addr
);
    localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

    logic [SKW-1:0] skip_q;
    logic           inc_q;
    logic [AW-1:0]  skip_ext;
    logic [AW-1:0]  next_addr;

    assign skip_ext = AW'($signed(skip_q));

    always_comb begin
        next_addr = addr;
        if (inc_q) begin
            if (step.boundary) begin
                next_addr = addr + STEP + skip_ext;
            end else begin
                next_addr = addr + STEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            skip_q <= '0;
            inc_q  <= 1'b0;
        end else if (start) begin
            addr   <= start_addr;
            skip_q <= skip;
            inc_q  <= inc_en;
        end else if (step.fire && !step.final_b) begin
            addr <= next_addr;
        end
    end

endmodule

// File: rtl/csag_count.sv
module csag_count
    import csag_pkg::*;
#(
    parameter int LW         = 20,
    parameter int BEAT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [LW-1:0] total,
    input  logic [LW-1:0] chunk,
    output logic          is_last,
    output logic          is_boundary,
    input  logic          fire
);
    localparam logic [LW-1:0] STEP = LW'(BEAT_BYTES);

    logic [LW-1:0] remain_q;
    logic [LW-1:0] chunk_left_q;
    logic [LW-1:0] chunk_q;
    logic          chunked;

    assign chunked     = (chunk_q != '0);
    assign is_last     = at_one_beat(32'(remain_q), BEAT_BYTES);
    assign is_boundary = chunked && at_one_beat(32'(chunk_left_q), BEAT_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q     <= '0;
            chunk_left_q <= '0;
            chunk_q      <= '0;
        end else if (start) begin
            remain_q     <= total;
            chunk_left_q <= chunk;
            chunk_q      <= chunk;
        end else if (fire && !is_last) begin
            remain_q <= remain_q - STEP;
            if (chunked) begin
                chunk_left_q <= is_boundary ? chunk_q : (chunk_left_q - STEP);
            end
        end else if (fire) begin
            remain_q <= '0;
        end
    end

endmodule

// File: rtl/csag_top.sv
module csag_top
    import csag_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LW         = 20,
    parameter int SKW        = 32,
    parameter int BEAT_BYTES = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [AW-1:0]  src_start,
    input  logic [AW-1:0]  dst_start,
    input  logic [LW-1:0]  total_bytes,
    input  logic [LW-1:0]  chunk_bytes,
    input  logic [SKW-1:0] src_skip,
    input  logic [SKW-1:0] dst_skip,
    input  logic           src_inc,
    input  logic           dst_inc,
    output logic           beat_valid,
    input  logic           beat_ready,
    output logic [AW-1:0]  beat_src,
    output logic [AW-1:0]  beat_dst,
    output logic           beat_last,
    output logic           done,
    output logic           busy_err,
    output logic [AW-1:0]  cur_src,
    output logic [AW-1:0]  cur_dst
);
    logic          active_q;
    logic          done_q;
    logic          err_q;
    logic          start_go;
    logic          empty_go;
    logic          cnt_last;
    logic          cnt_boundary;
    step_t         step;

    logic [AW-1:0]  start_arr [NUM_SIDES];
    logic [SKW-1:0] skip_arr  [NUM_SIDES];
    logic           inc_arr   [NUM_SIDES];
    logic [AW-1:0]  addr_arr  [NUM_SIDES];

    assign start_go = load && !active_q && (total_bytes != '0);
    assign empty_go = load && !active_q && (total_bytes == '0);

    assign step.fire     = active_q && beat_ready;
    assign step.final_b  = cnt_last;
    assign step.boundary = cnt_boundary;

    assign start_arr[SIDE_SRC] = src_start;
    assign start_arr[SIDE_DST] = dst_start;
    assign skip_arr[SIDE_SRC]  = src_skip;
    assign skip_arr[SIDE_DST]  = dst_skip;
    assign inc_arr[SIDE_SRC]   = src_inc;
    assign inc_arr[SIDE_DST]   = dst_inc;

    csag_count #(
        .LW         (LW),
        .BEAT_BYTES (BEAT_BYTES)
    ) i_count (
        .clk         (clk),
        .rst         (rst),
        .start       (start_go),
        .total       (total_bytes),
        .chunk       (chunk_bytes),
        .is_last     (cnt_last),
        .is_boundary (cnt_boundary),
        .fire        (step.fire)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        csag_side #(
            .AW         (AW),
            .SKW        (SKW),
            .BEAT_BYTES (BEAT_BYTES)
        ) i_side (
            .clk        (clk),
            .rst        (rst),
            .start      (start_go),
            .start_addr (start_arr[g]),
            .skip       (skip_arr[g]),
            .inc_en     (inc_arr[g]),
            .step       (step),
            .addr       (addr_arr[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= (step.fire && cnt_last) || empty_go;
            if (start_go) begin
                active_q <= 1'b1;
            end else if (step.fire && cnt_last) begin
                active_q <= 1'b0;
            end
            if (load && active_q) begin
                err_q <= 1'b1;
            end
        end
    end

    assign beat_valid = active_q;
    assign beat_last  = active_q && cnt_last;
    assign beat_src   = addr_arr[SIDE_SRC];
    assign beat_dst   = addr_arr[SIDE_DST];
    assign cur_src    = addr_arr[SIDE_SRC];
    assign cur_dst    = addr_arr[SIDE_DST];
    assign done       = done_q;
    assign busy_err   = err_q;

endmodule

// File: rtl/csag_chk.sv
module csag_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          load,
    input logic          beat_valid,
    input logic          beat_ready,
    input logic [AW-1:0] beat_src,
    input logic [AW-1:0] beat_dst,
    input logic          beat_last,
    input logic          done,
    input logic          busy_err
);
    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_src)
                                         && $stable(beat_dst) && $stable(beat_last)));

    // R8
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_ready && beat_last) |=> (done && !beat_valid));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> busy_err);

    // R9
    err_on_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (load && beat_valid) |=> busy_err);

    // R5
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        beat_last |-> beat_valid);

endmodule

bind csag_top csag_chk #(.AW(AW)) i_csag_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_src   (beat_src),
    .beat_dst   (beat_dst),
    .beat_last  (beat_last),
    .done       (done),
    .busy_err   (busy_err)
);

// File: tb/test_csag_top.sv
module test_csag_top;
    localparam int BEAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [31:0] src_start = '0;
    logic [31:0] dst_start = '0;
    logic [19:0] total_bytes = '0;
    logic [19:0] chunk_bytes = '0;
    logic [31:0] src_skip = '0;
    logic [31:0] dst_skip = '0;
    logic        src_inc = 1'b0;
    logic        dst_inc = 1'b0;
    logic        beat_valid;
    logic        beat_ready = 1'b0;
    logic [31:0] beat_src;
    logic [31:0] beat_dst;
    logic        beat_last;
    logic        done;
    logic        busy_err;
    logic [31:0] cur_src;
    logic [31:0] cur_dst;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    csag_top i_csag_top (
        .clk(clk), .rst(rst), .load(load),
        .src_start(src_start), .dst_start(dst_start),
        .total_bytes(total_bytes), .chunk_bytes(chunk_bytes),
        .src_skip(src_skip), .dst_skip(dst_skip),
        .src_inc(src_inc), .dst_inc(dst_inc),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_src(beat_src), .beat_dst(beat_dst), .beat_last(beat_last),
        .done(done), .busy_err(busy_err),
        .cur_src(cur_src), .cur_dst(cur_dst)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_xfer(input logic [31:0] s, input logic [31:0] d,
                            input int sz, input int ck,
                            input logic [31:0] ss, input logic [31:0] ds,
                            input bit si, input bit di, input bit stall,
                            input int inject_at, input string tag);
        logic [31:0] es = s, ed = d, ps = '0, pd = '0, lsrc = '0, ldst = '0;
        int rem = sz, cl = ck, nb = 0, cyc = 0;
        bit held = 0, plast = 0, injected = 0, rdy;
        @(negedge clk);
        src_start = s; dst_start = d; total_bytes = 20'(sz); chunk_bytes = 20'(ck);
        src_skip = ss; dst_skip = ds; src_inc = si; dst_inc = di; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(beat_valid && beat_src == s && beat_dst == d, "R2", beat_src, s);
        while (rem > 0 && cyc < 2000) begin
            load = 1'b0;
            rdy = stall ? (cyc % 3 != 2) : 1'b1;
            beat_ready = rdy;
            if (nb == inject_at && !injected && rdy) begin
                injected = 1;
                load = 1'b1; src_start = 32'hDEAD_0000; dst_start = 32'hBEEF_0000;
                total_bytes = 20'd64; chunk_bytes = 20'd0;
            end
            if (held)
                check(beat_valid && beat_src == ps && beat_dst == pd && beat_last == plast,
                      "R7", beat_src, ps);
            if (!beat_valid) begin
                check(0, tag, 32'(beat_valid), 32'd1);
                rem = 0;
            end else if (rdy) begin
                check(beat_src == es, tag, beat_src, es);
                check(beat_dst == ed, (!di) ? "R6" : tag, beat_dst, ed);
                check(beat_last == (rem == BEAT), "R5", 32'(beat_last), 32'(rem == BEAT));
                check(cur_src == es && cur_dst == ed, "R10", cur_src, es);
                lsrc = es; ldst = ed; nb++;
                if (rem == BEAT) begin
                    rem = 0;
                end else begin
                    if (ck != 0 && cl == BEAT) begin
                        if (si) es = es + 32'(BEAT) + ss;
                        if (di) ed = ed + 32'(BEAT) + ds;
                        cl = ck;
                    end else begin
                        if (si) es = es + 32'(BEAT);
                        if (di) ed = ed + 32'(BEAT);
                        cl = cl - BEAT;
                    end
                    rem = rem - BEAT;
                end
            end
            held = beat_valid && !rdy; ps = beat_src; pd = beat_dst; plast = beat_last;
            cyc++;
            @(negedge clk);
        end
        load = 1'b0;
        beat_ready = 1'b0;
        check(nb == sz / BEAT, (ck == 0) ? "R3" : "R4", 32'(nb), 32'(sz / BEAT));
        check(done && !beat_valid, "R8", 32'(done), 32'd1);
        check(cur_src == lsrc && cur_dst == ldst, "R10", cur_src, lsrc);
        @(negedge clk);
        check(!done, "R8", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(!beat_valid && !beat_last && !done && !busy_err, "R1", 32'(beat_valid), 32'd0);
        check(cur_src == 0 && cur_dst == 0, "R1", cur_src, 32'd0);

        // R3: contiguous
        run_xfer(32'h0000_1000, 32'h0000_8000, 32, 0, 32'd0, 32'd0, 1, 1, 0, -1, "R3");
        // R4 with R5 partial last chunk, stalls exercise R7
        run_xfer(32'h0000_2000, 32'h0000_9000, 40, 12, 32'd20, 32'd0, 1, 1, 1, -1, "R4");
        // R4 negative skips, one larger than the chunk
        run_xfer(32'h0000_4000, 32'h0000_A000, 32, 8, -32'sd24, -32'sd4, 1, 1, 1, -1, "R4");
        // R6 fixed destination with nonzero skip
        run_xfer(32'h0000_3000, 32'h0000_F00C, 24, 8, 32'd16, 32'd100, 1, 0, 0, -1, "R6");
        // R5 final beat on a chunk boundary, no skip after it
        run_xfer(32'h0000_5000, 32'h0000_6000, 16, 8, 32'd64, 32'd32, 1, 1, 0, -1, "R5");
        check(!busy_err, "R9", 32'(busy_err), 32'd0);
        // R9 load injected while active
        run_xfer(32'h0000_7000, 32'h0000_7800, 24, 8, 32'd8, 32'd0, 1, 1, 0, 1, "R9");
        check(busy_err, "R9", 32'(busy_err), 32'd1);
        repeat (3) @(negedge clk);
        check(busy_err, "R9", 32'(busy_err), 32'd1);

        // R11: zero-length load
        total_bytes = 20'd0; src_start = 32'h1234_0000; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        check(done && !beat_valid, "R11", 32'(done), 32'd1);
        @(negedge clk);
        check(!done && !beat_valid, "R11", 32'(done), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule